// File: doc/BRIEF.md
# Port Level-Change Detector

This block watches a group of input pins and raises a single shared change flag when any selected pin no longer matches a reference copy of the port. The reference copy is taken whenever software reads the port. A change therefore stays pending until software reads the port. Clearing the flag without that read sets it again on the next cycle.

Each pin has its own change-select bit, and one enable gates the flag onto the interrupt request. The flag does not say which pin changed. Software polls the read data, compares it with its own copy, and then clears the flag.

Every pin goes through a two-flop synchronizer before it is compared or captured. A pin set to analog mode reads as 0 and cannot cause a change.

Top module: `ioc_detector`

## Requirements
- R1: After reset the change flag and the request are 0. The reference copy is all 0 and the synchronizer holds all 0, so the read data is all 0.
- R2: A level on `pin_i` reaches `rd_data_o` after exactly two rising clock edges. It is still the old value after one edge.
- R3: If a pin with its select bit set differs from the reference bit, the flag is 1 after the next rising edge. The flag then stays 1 until a clear write.
- R4: A clear write that is not preceded by a port read does not clear the flag while the difference remains. The flag reads 1 after that edge.
- R5: A read strobe loads the reference with the synchronized, analog-masked pin levels at that edge. After a read, a following clear write leaves the flag at 0 while the pins stay steady.
- R6: `irq_o` is 1 only when the flag is 1 and `flag_en_i` is 1.
- R7: A pin whose `analog_i` bit is 1 reads as 0 on `rd_data_o` and never causes a difference.
- R8: A pin whose `mask_i` bit is 0 never sets the flag, whatever its level.
- R9: If a clear write arrives in the same cycle that a difference is present, the flag is 1 after that edge. Setting wins over clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | N_PINS | Raw pin levels, asynchronous |
| analog_i | input | N_PINS | Per-pin analog mode; 1 forces the digital value to 0 |
| mask_i | input | N_PINS | Per-pin change select; 1 lets the pin set the flag |
| port_rd_i | input | 1 | Port read strobe; loads the reference copy |
| flag_clr_i | input | 1 | Write that clears the change flag |
| flag_en_i | input | 1 | Lets the flag drive the request |
| flag_o | output | 1 | Shared change flag |
| irq_o | output | 1 | Interrupt request |
| rd_data_o | output | N_PINS | Synchronized digital port value |

## Verification
The bench builds the block with `N_PINS` = 4. This is enough to have one pin in analog mode, one pin masked off and two pins changing together in the same run, with every combination easy to follow by hand.

The synchronizer depth keeps its default of two, so the bench can count the cycles a pin change takes to reach the read data and the flag. With that count known, a clear write can be placed on the exact cycle a new difference first appears.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
  localparam int unsigned SYNC_DEPTH = 2;

  // any set bit where a and b differ, restricted to sel
  function automatic logic masked_diff(input logic [63:0] a, input logic [63:0] b,
                                       input logic [63:0] sel);
    return |((a ^ b) & sel);
  endfunction
endpackage

// File: rtl/ioc_sync.sv
module ioc_sync #(
  parameter int unsigned WIDTH = 6,
  parameter int unsigned DEPTH = ioc_pkg::SYNC_DEPTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [DEPTH-1:0] stage_q [WIDTH];

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= '0;
      else if (DEPTH > 1) stage_q[g] <= {stage_q[g][DEPTH-2:0], d_i[g]};
      else stage_q[g] <= d_i[g];
    end
    assign q_o[g] = stage_q[g][DEPTH-1];
  end
endmodule

// File: rtl/ioc_ref_cmp.sv
module ioc_ref_cmp #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] level_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic             capture_i,
  output logic             diff_o
);
  logic [WIDTH-1:0] ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= '0;
    else if (capture_i) ref_q <= level_i;
  end

  assign diff_o = ioc_pkg::masked_diff(64'(level_i), 64'(ref_q), 64'(mask_i));
endmodule

// File: rtl/ioc_flag.sv
module ioc_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else flag_q <= set_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ioc_detector.sv
module ioc_detector #(
  parameter int unsigned N_PINS = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_i,
  input  logic [N_PINS-1:0] analog_i,
  input  logic [N_PINS-1:0] mask_i,
  input  logic              port_rd_i,
  input  logic              flag_clr_i,
  input  logic              flag_en_i,
  output logic              flag_o,
  output logic              irq_o,
  output logic [N_PINS-1:0] rd_data_o
);
  logic [N_PINS-1:0] pin_sync;
  logic [N_PINS-1:0] dig_level;
  logic              diff;

  ioc_sync #(.WIDTH(N_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  assign dig_level = pin_sync & ~analog_i;

  ioc_ref_cmp #(.WIDTH(N_PINS)) u_cmp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .level_i  (dig_level),
    .mask_i   (mask_i),
    .capture_i(port_rd_i),
    .diff_o   (diff)
  );

  ioc_flag u_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (diff),
    .clr_i (flag_clr_i),
    .flag_o(flag_o)
  );

  assign irq_o     = flag_o & flag_en_i;
  assign rd_data_o = dig_level;
endmodule

// File: rtl/ioc_detector_chk.sv
module ioc_detector_chk #(
  parameter int unsigned N_PINS = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_PINS-1:0] analog_i,
  input logic              flag_clr_i,
  input logic              flag_en_i,
  input logic              flag_o,
  input logic              irq_o,
  input logic [N_PINS-1:0] rd_data_o,
  input logic              diff
);
  p_irq_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_o && flag_en_i));
  p_analog_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & analog_i) == '0);
  p_diff_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diff |=> flag_o);
  p_flag_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o);
  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (diff && flag_clr_i) |=> flag_o);
  p_clear_works_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!diff && flag_clr_i) |=> !flag_o);
endmodule

bind ioc_detector ioc_detector_chk #(.N_PINS(N_PINS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .analog_i  (analog_i),
  .flag_clr_i(flag_clr_i),
  .flag_en_i (flag_en_i),
  .flag_o    (flag_o),
  .irq_o     (irq_o),
  .rd_data_o (rd_data_o),
  .diff      (diff)
);

// File: tb/ioc_detector_tb.sv
module ioc_detector_tb;
  localparam int unsigned N = 4;
  localparam int unsigned NV = 13;
  // {pins, mask, analog, en, rd, clr, exp_flag, exp_irq, exp_rd}
  localparam logic [20:0] TBL [NV] = '{
    {4'b0000, 4'b1111, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000},
    {4'b0001, 4'b1111, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0001},
    {4'b0001, 4'b1111, 4'b0000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'b0001},
    {4'b0001, 4'b1111, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0001},
    {4'b0011, 4'b0001, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0011},
    {4'b0011, 4'b0011, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0011},
    {4'b0011, 4'b0011, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0011},
    {4'b0111, 4'b1111, 4'b0100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0011},
    {4'b0111, 4'b1111, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0111},
    {4'b0111, 4'b1111, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0111},
    {4'b0110, 4'b1110, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0110},
    {4'b0110, 4'b1111, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0110},
    {4'b0110, 4'b1111, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0110}
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] pin_i = '0, analog_i = '0, mask_i = '0;
  logic         port_rd_i = 1'b0, flag_clr_i = 1'b0, flag_en_i = 1'b0;
  logic         flag_o, irq_o;
  logic [N-1:0] rd_data_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  ioc_detector #(.N_PINS(N)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .analog_i(analog_i),
    .mask_i(mask_i), .port_rd_i(port_rd_i), .flag_clr_i(flag_clr_i),
    .flag_en_i(flag_en_i), .flag_o(flag_o), .irq_o(irq_o), .rd_data_o(rd_data_o)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    tick(2);
    // R1 reset state
    check("R1 flag", N'(flag_o), '0);
    check("R1 irq", N'(irq_o), '0);
    check("R1 rd", rd_data_o, '0);
    rst_ni = 1'b1;
    tick(1);

    for (int v = 0; v < NV; v++) begin
      logic [20:0] e;
      e = TBL[v];
      pin_i = e[20:17]; mask_i = e[16:13]; analog_i = e[12:9]; flag_en_i = e[8];
      tick(3);
      if (e[7]) begin port_rd_i = 1'b1; tick(1); port_rd_i = 1'b0; end
      if (e[6]) begin flag_clr_i = 1'b1; tick(1); flag_clr_i = 1'b0; end
      tick(1);
      // rows cover R3 R4 R5 R6 R7 R8
      check($sformatf("R3/R4/R5/R8 flag v%0d", v), N'(flag_o), N'(e[5]));
      check($sformatf("R6 irq v%0d", v), N'(irq_o), N'(e[4]));
      check($sformatf("R7 rd v%0d", v), rd_data_o, e[3:0]);
    end

    // R2 synchronizer latency: pins settled at 0110, ref 0110, flag 0
    pin_i = 4'b1110;
    tick(1);
    check("R2 one edge", rd_data_o, 4'b0110);
    check("R2 no flag yet", N'(flag_o), '0);
    tick(1);
    check("R2 two edges", rd_data_o, 4'b1110);
    // R9 clear lands on the first cycle of the difference
    flag_clr_i = 1'b1;
    tick(1);
    flag_clr_i = 1'b0;
    check("R9 set beats clear", N'(flag_o), 4'b0001);
    port_rd_i = 1'b1; tick(1); port_rd_i = 1'b0;
    flag_clr_i = 1'b1; tick(1); flag_clr_i = 1'b0;
    tick(2);
    check("R5 cleared after read", N'(flag_o), '0);
    // R8 masked pin flips repeatedly with no effect
    mask_i = 4'b0111;
    pin_i = 4'b0110; tick(4); pin_i = 4'b1110; tick(4);
    check("R8 masked pin", N'(flag_o), '0);
    // R1 async reset mid-run
    pin_i = 4'b0001; mask_i = '1; tick(4);
    rst_ni = 1'b0; #1;
    check("R1 flag on reset", N'(flag_o), '0);
    check("R1 rd on reset", rd_data_o, '0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule